// File: doc/BRIEF.md
# Audio codec link status register

This block presents one read-only 32-bit status word for an audio codec link controller. The word holds two kinds of indication. Two sticky flags record events: a frame start, and a wake-up request that the codec signals with a rising edge on its serial data-in line. Three live summary flags show whether any enabled event is pending on the codec channel, on channel A or on channel B. A live flag is the OR-reduction of the bitwise AND of that channel's status vector and mask vector.

Software reads the word by pulsing a single-cycle read strobe. The data comes back registered, with a valid pulse, one clock later. The same clock edge clears both sticky flags. An event that arrives in the cycle of the read is not lost. The live channel flags are never changed by a read; they follow their masked condition. The wake-up edge is caught by a flop that uses the data-in line as its clock. That flop re-arms itself through a clear derived in the system clock domain, and its output crosses into that domain through a two-flop synchronizer. An interrupt line is high whenever any of the five flags is set.

The read path is a plain register strobe rather than a stream. It has no back-pressure: every strobe produces exactly one valid pulse one cycle later, and the reader must take it in that cycle.

Top module: `alink_status`

## Requirements
- R1: After synchronous reset, with all inputs quiet, `rd_vld` and `irq` are 0, and a read returns 0.
- R2: Every cycle with `rd_stb` high is followed, in the next cycle, by `rd_vld` high with the word in `rd_data`. `rd_vld` is low in every other cycle.
- R3: Bit positions of the word: bit 0 frame-start flag, bit 1 wake-up flag, bit 2 codec channel event, bit 3 channel A event, bit 4 channel B event. Bits 31 down to 5 always read 0.
- R4: A one-cycle pulse on `sof_pulse` sets bit 0, and the bit stays set until a read.
- R5: A read returns bit 0 as it was before the read and clears it at the clock edge that registers the read data.
- R6: A `sof_pulse` in the same cycle as `rd_stb` is not returned by that read, and bit 0 is still set for the next read.
- R7: A rising edge on `sdin` sets bit 1 within five clock cycles, and the bit stays set until a read.
- R8: A read clears bit 1. A falling edge, or a steady level on `sdin`, does not set it.
- R9: Bits 2, 3 and 4 equal the OR-reduction of `co_st & co_mk`, `ca_st & ca_mk` and `cb_st & cb_mk` respectively, for every bit position of the 32-bit vectors.
- R10: A read does not clear bits 2 to 4. Each of them drops as soon as its masked condition is gone.
- R11: `irq` is high exactly when at least one of bits 0 to 4 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sof_pulse | input | 1 | One-cycle frame-start indication |
| sdin | input | 1 | Raw serial data-in line from the codec, asynchronous |
| co_st | input | 32 | Codec channel status vector |
| co_mk | input | 32 | Codec channel mask vector |
| ca_st | input | 32 | Channel A status vector |
| ca_mk | input | 32 | Channel A mask vector |
| cb_st | input | 32 | Channel B status vector |
| cb_mk | input | 32 | Channel B mask vector |
| rd_stb | input | 1 | Read strobe for the status word |
| rd_vld | output | 1 | Read data valid, one cycle after `rd_stb` |
| rd_data | output | 32 | Registered status word |
| irq | output | 1 | High while any status bit is set |

## Verification
The assertions check on every cycle the one-cycle read timing, the zero reserved bits, and that the sticky flags set on their events and clear on a read with no coincident event. They also check that the returned channel bits match the channel state of the read cycle and that any set flag raises the interrupt. Only the bench scenarios can show the end-to-end behaviour: the asynchronous wake-up capture from a real edge on `sdin`, the non-event of a falling edge, the read that coincides with a frame start, and the full per-bit sweep of the three masked-AND reductions.

// File: rtl/alink_status_pkg.sv
package alink_status_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_SOF = 0;
  localparam int BIT_WK  = 1;
  localparam int BIT_EV0 = 2;
  localparam int N_CH    = 3;
  localparam int N_FLAGS = BIT_EV0 + N_CH;
endpackage

// File: rtl/alink_sticky.sv
module alink_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // A set in the clear cycle wins, so the event survives the read.
  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/alink_wake_cap.sv
module alink_wake_cap #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sdin,
  output logic edge_o
);
  logic raw_q;
  logic rearm_q;
  logic [SYNC_N:0] sync_q;

  // Edge catcher clocked by the line itself, emptied from the clk domain.
  always_ff @(posedge sdin or posedge rearm_q) begin
    if (rearm_q) raw_q <= 1'b0;
    else         raw_q <= 1'b1;
  end

  // Synchronizer plus one history stage for the rise detect.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-1:0], raw_q};
  end

  // Re-arm once the capture has been seen; also empty it during reset.
  always_ff @(posedge clk) begin
    if (rst) rearm_q <= 1'b1;
    else     rearm_q <= sync_q[SYNC_N-1];
  end

  assign edge_o = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
endmodule

// File: rtl/alink_chan_evt.sv
module alink_chan_evt #(
  parameter int VEC_W = 32,
  parameter int NCH   = 3
) (
  input  logic [NCH-1:0][VEC_W-1:0] st_i,
  input  logic [NCH-1:0][VEC_W-1:0] mk_i,
  output logic [NCH-1:0]            ev_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ev_o[c] = |(st_i[c] & mk_i[c]);
  end
endmodule

// File: rtl/alink_status.sv
module alink_status
  import alink_status_pkg::*;
#(
  parameter int VEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_pulse,
  input  logic             sdin,
  input  logic [VEC_W-1:0] co_st,
  input  logic [VEC_W-1:0] co_mk,
  input  logic [VEC_W-1:0] ca_st,
  input  logic [VEC_W-1:0] ca_mk,
  input  logic [VEC_W-1:0] cb_st,
  input  logic [VEC_W-1:0] cb_mk,
  input  logic             rd_stb,
  output logic             rd_vld,
  output logic [WORD_W-1:0] rd_data,
  output logic             irq
);
  logic [N_CH-1:0][VEC_W-1:0] st_v, mk_v;
  logic [N_CH-1:0]            ch_ev;
  logic                       sof_q, wk_q, wk_pulse;
  logic [N_FLAGS-1:0]         flags;
  logic [WORD_W-1:0]          word;

  assign st_v = {cb_st, ca_st, co_st};
  assign mk_v = {cb_mk, ca_mk, co_mk};

  alink_chan_evt #(.VEC_W(VEC_W), .NCH(N_CH)) u_ev (
    .st_i(st_v), .mk_i(mk_v), .ev_o(ch_ev)
  );

  alink_wake_cap #(.SYNC_N(2)) u_wk (
    .clk(clk), .rst(rst), .sdin(sdin), .edge_o(wk_pulse)
  );

  alink_sticky u_sof (
    .clk(clk), .rst(rst), .set_i(sof_pulse), .clr_i(rd_stb), .q_o(sof_q)
  );

  alink_sticky u_wkf (
    .clk(clk), .rst(rst), .set_i(wk_pulse), .clr_i(rd_stb), .q_o(wk_q)
  );

  assign flags = {ch_ev, wk_q, sof_q};

  always_comb begin
    word = '0;
    word[N_FLAGS-1:0] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_stb;
      if (rd_stb) rd_data <= word;
    end
  end

  assign irq = |flags;
endmodule

// File: rtl/alink_status_chk.sv
module alink_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        sof_pulse,
  input logic        rd_stb,
  input logic        rd_vld,
  input logic [31:0] rd_data,
  input logic        irq,
  input logic        sof_q,
  input logic        wk_q,
  input logic        wk_pulse,
  input logic [2:0]  ev
);
  // R2
  rd_vld_lat_chk: assert property (@(posedge clk) disable iff (rst) rd_stb |=> rd_vld);
  // R2
  no_spur_vld_chk: assert property (@(posedge clk) disable iff (rst) !rd_stb |=> !rd_vld);
  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst) rd_vld |-> rd_data[31:5] == 27'd0);
  // R4
  sof_set_chk: assert property (@(posedge clk) disable iff (rst) sof_pulse |=> sof_q);
  // R5
  sof_clr_chk: assert property (@(posedge clk) disable iff (rst) (rd_stb && !sof_pulse) |=> !sof_q);
  // R7
  wk_set_chk: assert property (@(posedge clk) disable iff (rst) wk_pulse |=> wk_q);
  // R8
  wk_clr_chk: assert property (@(posedge clk) disable iff (rst) (rd_stb && !wk_pulse) |=> !wk_q);
  // R10
  ev_read_chk: assert property (@(posedge clk) disable iff (rst) rd_stb |=> rd_data[4:2] == $past(ev));
  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst) (sof_q || wk_q || ev != 3'd0) |-> irq);
endmodule

bind alink_status alink_status_chk u_chk (
  .clk(clk), .rst(rst), .sof_pulse(sof_pulse), .rd_stb(rd_stb),
  .rd_vld(rd_vld), .rd_data(rd_data), .irq(irq),
  .sof_q(sof_q), .wk_q(wk_q), .wk_pulse(wk_pulse), .ev(ch_ev)
);

// File: tb/alink_status_tb.sv
module alink_status_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof_pulse = 1'b0;
  logic sdin = 1'b0;
  logic [31:0] co_st = '0, co_mk = '0, ca_st = '0, ca_mk = '0, cb_st = '0, cb_mk = '0;
  logic rd_stb = 1'b0;
  logic rd_vld;
  logic [31:0] rd_data;
  logic irq;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  alink_status u_dut (
    .clk(clk), .rst(rst), .sof_pulse(sof_pulse), .sdin(sdin),
    .co_st(co_st), .co_mk(co_mk), .ca_st(ca_st), .ca_mk(ca_mk),
    .cb_st(cb_st), .cb_mk(cb_mk), .rd_stb(rd_stb), .rd_vld(rd_vld),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe for one cycle; the word is sampled at the following falling edge.
  task automatic rd_word(input string req, input logic [31:0] exp);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk(req, {31'd0, rd_vld}, 32'd1);
    chk(req, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(input int c, input logic [31:0] s, input logic [31:0] m);
    co_st = '0; co_mk = '0; ca_st = '0; ca_mk = '0; cb_st = '0; cb_mk = '0;
    case (c)
      0: begin co_st = s; co_mk = m; end
      1: begin ca_st = s; ca_mk = m; end
      default: begin cb_st = s; cb_mk = m; end
    endcase
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] s, m, e;
    idle(4);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 vld", {31'd0, rd_vld}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd_word("R1 word", 32'd0);
    // R2 valid falls after single strobe
    @(negedge clk);
    chk("R2 vld low", {31'd0, rd_vld}, 32'd0);

    // R4 sticky frame start, R11 irq
    @(negedge clk); sof_pulse = 1'b1;
    @(negedge clk); sof_pulse = 1'b0;
    idle(3);
    chk("R11 irq sof", {31'd0, irq}, 32'd1);
    rd_word("R4 sof set", 32'h1);
    // R5 cleared by the read
    chk("R11 irq clear", {31'd0, irq}, 32'd0);
    rd_word("R5 sof cleared", 32'h0);

    // R6 coincident frame start and read
    @(negedge clk); sof_pulse = 1'b1; rd_stb = 1'b1;
    @(negedge clk); sof_pulse = 1'b0; rd_stb = 1'b0;
    chk("R6 old value", rd_data, 32'h0);
    rd_word("R6 kept", 32'h1);
    rd_word("R6 then clear", 32'h0);

    // R7 wake-up on rising edge
    @(negedge clk); sdin = 1'b1;
    idle(6);
    chk("R11 irq wake", {31'd0, irq}, 32'd1);
    rd_word("R7 wake set", 32'h2);
    rd_word("R8 wake cleared", 32'h0);
    // R8 steady high and falling edge do not set
    idle(8);
    @(negedge clk); sdin = 1'b0;
    idle(8);
    rd_word("R8 fall ignored", 32'h0);
    // R7 a second edge after re-arm
    @(negedge clk); sdin = 1'b1;
    idle(6);
    rd_word("R7 second edge", 32'h2);
    @(negedge clk); sdin = 1'b0;
    idle(4);

    // R9 per-bit sweep of each channel with four mask patterns
    for (int c = 0; c < 3; c++) begin
      for (int j = 0; j < 32; j++) begin
        for (int p = 0; p < 4; p++) begin
          s = 32'd1 << j;
          case (p)
            0: m = s;
            1: m = ~s;
            2: m = 32'hFFFF_FFFF;
            default: m = 32'd1 << ((j + 1) % 32);
          endcase
          e = ((s & m) != 0) ? (32'd1 << (2 + c)) : 32'd0;
          set_ch(c, s, m);
          rd_word("R9 sweep", e);
          chk("R11 irq live", {31'd0, irq}, {31'd0, (e != 0)});
        end
      end
    end

    // R10 read does not clear live bits; condition removal does
    set_ch(1, 32'h8000_0001, 32'h0000_0001);
    rd_word("R10 first read", 32'h8);
    rd_word("R10 second read", 32'h8);
    @(negedge clk); ca_mk = 32'h0;
    rd_word("R10 dropped", 32'h0);
    // R3 all flags at once, reserved bits zero
    set_ch(0, 32'h10, 32'h10);
    ca_st = 32'h4; ca_mk = 32'h4; cb_st = 32'h2; cb_mk = 32'h3;
    @(negedge clk); sof_pulse = 1'b1; sdin = 1'b1;
    @(negedge clk); sof_pulse = 1'b0;
    idle(6);
    rd_word("R3 all flags", 32'h1F);
    set_ch(0, 32'h0, 32'h0);
    rd_word("R3 after clear", 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule